// File: doc/BRIEF.md
# Vector Execution Unit with Reductions

This block is a small vector functional unit. It holds a bank of short vector registers inside itself and runs one instruction at a time across every element of a vector. A caller presents an operation code, a destination index, one or two source indices and a scalar operand, then pulses `start`. The unit captures those fields once, at acceptance. It then walks the elements in ascending order and does not look at the instruction inputs again until it is idle.

Four kinds of work go through one shared element datapath:
- **Unary vector-to-vector:** integer square root, worked out one result bit per cycle.
- **Binary vector-to-vector:** element-wise add.
- **Scalar broadcast:** add or divide every element by a scalar.
- **Reductions:** maximum, minimum, sum and dot product, each producing a scalar.

Each element written back to a register also appears on a write-back port, so the register contents can be seen from outside. Reduction results appear on `scalar_out`, and `done` marks the end of every instruction.

Top module: `vexu_top`

## Requirements
- R1: After reset `busy`, `done`, `wb_valid` and `div_err` are low and `scalar_out` is 0. Element e of register r holds (r*4096 + e*293 + 7) mod 65536.
- R2: A `start` seen while idle at a clock edge T0 latches all instruction fields. `busy` is high from T0 on. For every operation except square root, one element is processed per edge, element 0 first. `done` is high for exactly one cycle, set by edge T0+8, and `busy` falls at that same edge.
- R3: `start` is ignored while `busy` is high. Changed fields have no effect on the running instruction, and no new instruction begins after `done`.
- R4: Opcode 0 writes floor(sqrt(a[e])) into dst[e]. Each element takes 8 cycles, so `done` is set by edge T0+64.
- R5: Opcode 1 writes (a[e] + b[e]) mod 65536 into dst[e].
- R6: Opcode 2 writes (a[e] + scalar) mod 65536 into dst[e].
- R7: Opcode 3 writes floor(a[e] / scalar) into dst[e]. With a zero scalar it writes 65535 and sets `div_err`, which stays set until reset.
- R8: Opcode 4 returns the maximum of a[0..7] on `scalar_out`, and opcode 5 returns the minimum, both zero-extended.
- R9: Opcode 6 returns the sum of a[0..7] modulo 2^32 on `scalar_out`.
- R10: Opcode 7 returns the sum over e of a[e]*b[e] modulo 2^32 on `scalar_out`.
- R11: Reductions (opcodes 4 to 7) write no register and raise no `wb_valid`. Vector operations (opcodes 0 to 3) leave `scalar_out` unchanged.
- R12: Each element write is shown on `wb_valid`/`wb_reg`/`wb_elem`/`wb_data` one cycle after it is computed. The write goes into the register file at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction when idle |
| opcode | input | 3 | Operation code 0..7 |
| dst_sel | input | 3 | Destination vector register |
| srca_sel | input | 3 | First source vector register |
| srcb_sel | input | 3 | Second source vector register |
| scalar_in | input | 16 | Scalar operand |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |
| wb_valid | output | 1 | An element was written |
| wb_reg | output | 3 | Register index of the write |
| wb_elem | output | 3 | Element index of the write |
| wb_data | output | 16 | Value written |
| scalar_out | output | 32 | Last reduction result |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
The accepting edge is counted as T0.

- **Add, scalar and reduction operations:** element e's write-back shows after edge T0+1+e, and `done` with any scalar result shows after edge T0+8.
- **Square root:** element e's write-back shows after edge T0+8(e+1), with `done` after T0+64.

The bench drives inputs and samples outputs on falling edges. After the accepting edge it counts rising edges one by one, checking each write-back against the element index expected at that count. It requires `done` at exactly the computed count, and checks on the next falling edge that the unit is idle again.

// File: rtl/vexu_pkg.sv
package vexu_pkg;
   typedef enum logic [2:0] {
      OP_VSQRT = 3'd0,
      OP_VADD  = 3'd1,
      OP_SADD  = 3'd2,
      OP_SDIV  = 3'd3,
      OP_RMAX  = 3'd4,
      OP_RMIN  = 3'd5,
      OP_RSUM  = 3'd6,
      OP_RDOT  = 3'd7
   } vexu_op_e;

   function automatic logic is_reduce(vexu_op_e op);
      return (op == OP_RMAX) || (op == OP_RMIN) || (op == OP_RSUM) || (op == OP_RDOT);
   endfunction
endpackage

// File: rtl/vexu_rf.sv
module vexu_rf #(
   parameter int NREG  = 8,
   parameter int NELEM = 8,
   parameter int EW    = 16,
   localparam int RIW  = $clog2(NREG),
   localparam int EIW  = $clog2(NELEM)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [RIW-1:0] rd_a_reg,
   input  logic [RIW-1:0] rd_b_reg,
   input  logic [EIW-1:0] rd_elem,
   output logic [EW-1:0]  rd_a,
   output logic [EW-1:0]  rd_b,
   input  logic           we,
   input  logic [RIW-1:0] wr_reg,
   input  logic [EIW-1:0] wr_elem,
   input  logic [EW-1:0]  wr_data
);
   function automatic logic [EW-1:0] seed_val(int r, int e);
      int unsigned v;
      v = r * 4096 + e * 293 + 7;
      return EW'(v);
   endfunction

   logic [EW-1:0] mem [NREG][NELEM];

   assign rd_a = mem[rd_a_reg][rd_elem];
   assign rd_b = mem[rd_b_reg][rd_elem];

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      for (genvar e = 0; e < NELEM; e++) begin : g_elem
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[r][e] <= seed_val(r, e);
            else if (we && wr_reg == RIW'(r) && wr_elem == EIW'(e))
               mem[r][e] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/vexu_lane.sv
module vexu_lane
   import vexu_pkg::*;
#(
   parameter int EW  = 16,
   parameter int AW  = 32,
   localparam int RW = EW / 2,
   localparam int BW = $clog2(RW)
) (
   input  vexu_op_e       op,
   input  logic           first,
   input  logic [EW-1:0]  va,
   input  logic [EW-1:0]  vb,
   input  logic [EW-1:0]  sc,
   input  logic [AW-1:0]  acc_q,
   input  logic [RW-1:0]  root_q,
   input  logic [BW-1:0]  bitc,
   output logic [EW-1:0]  vec_res,
   output logic [RW-1:0]  root_nxt,
   output logic [AW-1:0]  acc_nxt,
   output logic           div_zero
);
   logic [RW-1:0] trial;
   logic [EW-1:0] trial_w, trial_sq;
   logic [AW-1:0] ext_a, prod, base;

   // one result bit per call: keep the trial bit if its square still fits
   always_comb begin
      trial    = root_q | (RW'(1) << bitc);
      trial_w  = EW'(trial);
      trial_sq = trial_w * trial_w;
      root_nxt = (trial_sq <= va) ? trial : root_q;
   end

   assign div_zero = (sc == '0);
   assign ext_a    = AW'(va);
   assign prod     = AW'(va) * AW'(vb);
   assign base     = first ? '0 : acc_q;

   always_comb begin
      case (op)
         OP_VSQRT: vec_res = EW'(root_nxt);
         OP_VADD:  vec_res = va + vb;
         OP_SADD:  vec_res = va + sc;
         OP_SDIV:  vec_res = div_zero ? '1 : va / sc;
         default:  vec_res = '0;
      endcase
   end

   always_comb begin
      case (op)
         OP_RMAX: acc_nxt = (first || ext_a > acc_q) ? ext_a : acc_q;
         OP_RMIN: acc_nxt = (first || ext_a < acc_q) ? ext_a : acc_q;
         OP_RSUM: acc_nxt = base + ext_a;
         OP_RDOT: acc_nxt = base + prod;
         default: acc_nxt = acc_q;
      endcase
   end
endmodule

// File: rtl/vexu_seq.sv
module vexu_seq
   import vexu_pkg::*;
#(
   parameter int NREG  = 8,
   parameter int NELEM = 8,
   parameter int EW    = 16,
   localparam int RIW  = $clog2(NREG),
   localparam int EIW  = $clog2(NELEM),
   localparam int RW   = EW / 2,
   localparam int BW   = $clog2(RW)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [2:0]     opcode,
   input  logic [RIW-1:0] dst_sel,
   input  logic [RIW-1:0] srca_sel,
   input  logic [RIW-1:0] srcb_sel,
   input  logic [EW-1:0]  scalar_in,
   output logic           busy,
   output logic           done,
   output vexu_op_e       cur_op,
   output logic [RIW-1:0] cur_dst,
   output logic [RIW-1:0] cur_a,
   output logic [RIW-1:0] cur_b,
   output logic [EW-1:0]  cur_s,
   output logic [EIW-1:0] elem,
   output logic [BW-1:0]  bitc,
   output logic           elem_done,
   output logic           last
);
   logic accept;

   assign accept    = start && !busy;
   assign elem_done = busy && (cur_op != OP_VSQRT || bitc == '0);
   assign last      = elem_done && (elem == EIW'(NELEM - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         cur_op  <= OP_VADD;
         cur_dst <= '0;
         cur_a   <= '0;
         cur_b   <= '0;
         cur_s   <= '0;
         elem    <= '0;
         bitc    <= BW'(RW - 1);
      end else begin
         done <= last;
         if (accept) begin
            busy    <= 1'b1;
            cur_op  <= vexu_op_e'(opcode);
            cur_dst <= dst_sel;
            cur_a   <= srca_sel;
            cur_b   <= srcb_sel;
            cur_s   <= scalar_in;
            elem    <= '0;
            bitc    <= BW'(RW - 1);
         end else if (busy) begin
            if (elem_done) begin
               elem <= elem + 1'b1;
               bitc <= BW'(RW - 1);
               if (last) busy <= 1'b0;
            end else begin
               bitc <= bitc - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/vexu_top.sv
module vexu_top
   import vexu_pkg::*;
#(
   parameter int NREG  = 8,
   parameter int NELEM = 8,
   parameter int EW    = 16,
   parameter int AW    = 32,
   localparam int RIW  = $clog2(NREG),
   localparam int EIW  = $clog2(NELEM),
   localparam int RW   = EW / 2,
   localparam int BW   = $clog2(RW)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [2:0]     opcode,
   input  logic [RIW-1:0] dst_sel,
   input  logic [RIW-1:0] srca_sel,
   input  logic [RIW-1:0] srcb_sel,
   input  logic [EW-1:0]  scalar_in,
   output logic           busy,
   output logic           done,
   output logic           wb_valid,
   output logic [RIW-1:0] wb_reg,
   output logic [EIW-1:0] wb_elem,
   output logic [EW-1:0]  wb_data,
   output logic [AW-1:0]  scalar_out,
   output logic           div_err
);
   if (EW < 4 || (EW % 2) != 0) begin : g_bad_ew
      $error("vexu_top: EW must be even and at least 4");
   end
   if (AW < 2 * EW) begin : g_bad_aw
      $error("vexu_top: AW must hold a full product");
   end
   if (NREG < 2 || NELEM < 2 || (NELEM & (NELEM - 1)) != 0) begin : g_bad_shape
      $error("vexu_top: NREG >= 2 and NELEM a power of two >= 2 required");
   end

   vexu_op_e       cur_op;
   logic [RIW-1:0] cur_dst, cur_a, cur_b;
   logic [EW-1:0]  cur_s, va, vb, vec_res;
   logic [EIW-1:0] elem;
   logic [BW-1:0]  bitc;
   logic           elem_done, last, div_zero, red, vec_we;
   logic [RW-1:0]  root_q, root_nxt;
   logic [AW-1:0]  acc_q, acc_nxt;

   vexu_seq #(.NREG(NREG), .NELEM(NELEM), .EW(EW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .dst_sel(dst_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
      .scalar_in(scalar_in), .busy(busy), .done(done), .cur_op(cur_op),
      .cur_dst(cur_dst), .cur_a(cur_a), .cur_b(cur_b), .cur_s(cur_s),
      .elem(elem), .bitc(bitc), .elem_done(elem_done), .last(last)
   );

   assign red    = is_reduce(cur_op);
   assign vec_we = elem_done && !red;

   vexu_rf #(.NREG(NREG), .NELEM(NELEM), .EW(EW)) u_rf (
      .clk(clk), .rst_n(rst_n), .rd_a_reg(cur_a), .rd_b_reg(cur_b),
      .rd_elem(elem), .rd_a(va), .rd_b(vb), .we(vec_we),
      .wr_reg(cur_dst), .wr_elem(elem), .wr_data(vec_res)
   );

   vexu_lane #(.EW(EW), .AW(AW)) u_lane (
      .op(cur_op), .first(elem == '0), .va(va), .vb(vb), .sc(cur_s),
      .acc_q(acc_q), .root_q(root_q), .bitc(bitc), .vec_res(vec_res),
      .root_nxt(root_nxt), .acc_nxt(acc_nxt), .div_zero(div_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         root_q     <= '0;
         acc_q      <= '0;
         scalar_out <= '0;
         div_err    <= 1'b0;
         wb_valid   <= 1'b0;
         wb_reg     <= '0;
         wb_elem    <= '0;
         wb_data    <= '0;
      end else begin
         wb_valid <= vec_we;
         if (busy && cur_op == OP_VSQRT)
            root_q <= elem_done ? '0 : root_nxt;
         if (elem_done)
            acc_q <= acc_nxt;
         if (last && red)
            scalar_out <= acc_nxt;
         if (elem_done && cur_op == OP_SDIV && div_zero)
            div_err <= 1'b1;
         if (vec_we) begin
            wb_reg  <= cur_dst;
            wb_elem <= elem;
            wb_data <= vec_res;
         end
      end
   end
endmodule

// File: rtl/vexu_chk.sv
module vexu_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic wb_valid,
   input logic div_err
);
   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_ends_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_busy_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_idle_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_wb_in_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> $past(busy));

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      div_err |=> div_err);
endmodule

bind vexu_top vexu_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
   .done(done), .wb_valid(wb_valid), .div_err(div_err)
);

// File: tb/sim_vexu_top.sv
`timescale 1ns/1ps
module sim_vexu_top;
   logic        clk = 1'b0;
   logic        rst_n, start;
   logic [2:0]  opcode, dst_sel, srca_sel, srcb_sel;
   logic [15:0] scalar_in;
   logic        busy, done, wb_valid, div_err;
   logic [2:0]  wb_reg, wb_elem;
   logic [15:0] wb_data;
   logic [31:0] scalar_out;

   always #4 clk = ~clk;

   vexu_top u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .dst_sel(dst_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
      .scalar_in(scalar_in), .busy(busy), .done(done), .wb_valid(wb_valid),
      .wb_reg(wb_reg), .wb_elem(wb_elem), .wb_data(wb_data),
      .scalar_out(scalar_out), .div_err(div_err)
   );

   int checks = 0;
   int errors = 0;
   logic [15:0] mdl [8][8];
   bit err_m = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int isq(int x);
      int r = 0;
      while ((r + 1) * (r + 1) <= x) r++;
      return r;
   endfunction

   function automatic string tag_of(int op);
      case (op)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         3: return "R7";
         4, 5: return "R8";
         6: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic run_op(input int op, input int d, input int a, input int b,
                         input int s, input bit poke);
      logic [15:0] ev [8];
      logic [31:0] es, prev, p;
      bit red, got;
      int lat_exp, nel;
      string tag;
      red = (op >= 4);
      tag = tag_of(op);
      lat_exp = (op == 0) ? 64 : 8;
      es = 0;
      for (int e = 0; e < 8; e++) begin
         case (op)
            0: ev[e] = 16'(isq(int'(mdl[a][e])));
            1: ev[e] = mdl[a][e] + mdl[b][e];
            2: ev[e] = mdl[a][e] + 16'(s);
            3: ev[e] = (s == 0) ? 16'hFFFF : 16'(int'(mdl[a][e]) / s);
            default: ev[e] = 16'h0;
         endcase
         p = {16'h0, mdl[a][e]} * {16'h0, mdl[b][e]};
         case (op)
            4: es = (e == 0 || {16'h0, mdl[a][e]} > es) ? {16'h0, mdl[a][e]} : es;
            5: es = (e == 0 || {16'h0, mdl[a][e]} < es) ? {16'h0, mdl[a][e]} : es;
            6: es = es + {16'h0, mdl[a][e]};
            7: es = es + p;
            default: es = es;
         endcase
      end
      @(negedge clk);
      prev = scalar_out;
      start = 1'b1; opcode = 3'(op); dst_sel = 3'(d); srca_sel = 3'(a);
      srcb_sel = 3'(b); scalar_in = 16'(s);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2", busy, 1);
      nel = 0; got = 0;
      for (int k = 1; k <= lat_exp + 4 && !got; k++) begin
         if (poke && k == 2) begin
            start = 1'b1; opcode = 3'((op + 3) % 8); dst_sel = 3'((d + 1) % 8);
            srca_sel = 3'(b); scalar_in = 16'h0;
         end
         if (poke && k == 3) start = 1'b0;
         @(negedge clk);
         if (wb_valid) begin
            chk(!red, "R11", 1, 0);
            if (nel < 8) begin
               chk(int'(wb_reg) == d && int'(wb_elem) == nel, "R12",
                   {wb_reg, wb_elem}, {d[2:0], nel[2:0]});
               chk(wb_data == ev[nel], poke ? "R3" : tag, wb_data, ev[nel]);
               if (op == 0 && nel > 0)
                  chk(k == 8 * (nel + 1), "R4", k, 8 * (nel + 1));
               if (op != 0)
                  chk(k == nel + 1, "R2", k, nel + 1);
            end
            nel++;
         end
         if (done) begin
            got = 1;
            chk(k == lat_exp, (op == 0) ? "R4" : "R2", k, lat_exp);
         end
      end
      chk(got, "R2", got, 1);
      chk(nel == (red ? 0 : 8), red ? "R11" : "R2", nel, red ? 0 : 8);
      if (red) chk(scalar_out == es, poke ? "R3" : tag, scalar_out, es);
      else     chk(scalar_out == prev, "R11", scalar_out, prev);
      if (op == 3 && s == 0) err_m = 1;
      chk(div_err == err_m, "R7", div_err, err_m);
      @(negedge clk);
      chk(!done && !busy, "R3", {done, busy}, 0);
      if (!red)
         for (int e = 0; e < 8; e++) mdl[d][e] = ev[e];
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; opcode = '0; dst_sel = '0;
      srca_sel = '0; srcb_sel = '0; scalar_in = '0;
      for (int r = 0; r < 8; r++)
         for (int e = 0; e < 8; e++)
            mdl[r][e] = 16'(r * 4096 + e * 293 + 7);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      chk(!busy && !done && !wb_valid && !div_err, "R1",
          {busy, done, wb_valid, div_err}, 0);
      chk(scalar_out == 0, "R1", scalar_out, 0);
      // R1 seed contents observed through reductions (R8, R9, R10)
      for (int r = 0; r < 8; r++) begin
         run_op(6, 0, r, 0, 0, 0);
         run_op(4, 0, r, 0, 0, 0);
         run_op(5, 0, r, 0, 0, 0);
         run_op(7, 0, r, (r + 5) % 8, 0, 0);
      end
      // R5 element-wise add sweep, including in-place
      for (int d = 0; d < 8; d++) run_op(1, d, (d + 1) % 8, (d + 2) % 8, 0, 0);
      run_op(1, 3, 3, 3, 0, 0);
      // R6 scalar add, wrap cases
      run_op(2, 0, 1, 0, 1, 0);
      run_op(2, 1, 2, 0, 65535, 0);
      run_op(2, 2, 3, 0, 12345, 0);
      run_op(2, 4, 4, 0, 40000, 0);
      // R7 scalar divide, nonzero then zero
      run_op(3, 5, 0, 0, 1, 0);
      run_op(3, 6, 1, 0, 7, 0);
      run_op(3, 7, 2, 0, 300, 0);
      run_op(3, 5, 4, 0, 0, 0);
      run_op(6, 0, 5, 0, 0, 0);
      // build all-zero then all-ones register 6
      run_op(3, 6, 6, 0, 65535, 0);
      run_op(3, 6, 6, 0, 65535, 0);
      run_op(4, 0, 6, 0, 0, 0);
      run_op(2, 6, 6, 0, 65535, 0);
      run_op(4, 0, 6, 0, 0, 0);
      run_op(6, 0, 6, 0, 0, 0);
      run_op(7, 0, 6, 6, 0, 0);
      // R4 square root, extremes and assorted values
      run_op(0, 7, 6, 0, 0, 0);
      run_op(5, 0, 7, 0, 0, 0);
      run_op(0, 0, 0, 0, 0, 0);
      run_op(0, 1, 3, 0, 0, 0);
      run_op(0, 2, 2, 0, 0, 0);
      // R3 start pulses while busy
      run_op(1, 2, 0, 1, 0, 1);
      run_op(0, 1, 4, 4, 0, 1);
      run_op(6, 0, 2, 0, 0, 1);
      run_op(3, 3, 3, 0, 5, 1);
      // final reductions after all updates
      for (int r = 0; r < 8; r++) run_op(7, 0, r, (r + 1) % 8, 0, 0);
      summary();
      $finish;
   end
endmodule